// File: doc/BRIEF.md
# Clock Generator Configuration Register Bank

This block holds the byte-wide configuration image of a programmable clock generator. A serial host controller, with its framing already stripped, hands the block a stream of bytes. The first byte of a transfer is an address. Each byte after it is a data beat. A data beat either writes the register under the pointer or asks for it to be read. In both cases the pointer then moves up by one.

Some locations are fixed. These are the factory block at the bottom of the map and three scattered single locations. They keep the values they load at reset and never accept data. One bit in the last register acts as a global-reset control. When that bit goes from 0 to 1 through a host write, the block issues a single-cycle apply strobe so the output dividers pick up their pending settings. The whole register image is also presented in parallel to the rest of the clock generator.

Both streams use valid/ready handshakes.
- **Host stream:** a beat transfers on a rising edge where `host_valid` and `host_ready` are both high. `host_ready` falls only while a read result is waiting and `resp_ready` is low.
- **Response stream:** a result in `resp_data` stays unchanged while `resp_valid` is high and `resp_ready` is low.

Top module: `cfgrf_top`

## Requirements
- R1: After reset, every writable register reads 0x00, every fixed register holds its address XOR 0x5A, `resp_valid` is 0 and `apply_pulse` is 0.
- R2: A write beat stores `host_data` into the register at the pointer. The pointer then advances, so a five-byte write burst that starts at 0x17 fills 0x17 through 0x1B in order.
- R3: A read beat returns the register at the pointer on `resp_data`, with `resp_valid` high from the cycle after the beat. The pointer then advances.
- R4: Addresses 0x00 to 0x0F ignore writes and always read their reset value (address XOR 0x5A).
- R5: Addresses 0x14, 0x1C and 0x1D also ignore writes and keep address XOR 0x5A. Every other address up to 0x76 accepts writes.
- R6: A write to an address above 0x76 changes nothing, and a read there returns 0x00.
- R7: After a data beat at 0x76, the pointer stays at 0x76 and does not wrap.
- R8: A write beat to 0x76 with bit 5 set, while the stored bit 5 is 0, makes `apply_pulse` high for exactly the next cycle.
- R9: A write to 0x76 with bit 5 set, while the stored bit 5 is already 1, produces no pulse.
- R10: While `resp_valid` is high and `resp_ready` is low, `resp_data` holds and `host_ready` is low.
- R11: A beat with `host_first` high only loads the pointer. It writes nothing and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host beat offered |
| host_ready | output | 1 | Block accepts a beat this cycle |
| host_first | input | 1 | Beat is an address byte |
| host_write | input | 1 | Data beat is a write (1) or a read (0) |
| host_data | input | 8 | Address or data byte |
| resp_valid | output | 1 | Read result available |
| resp_ready | input | 1 | Host takes the read result |
| resp_data | output | 8 | Read result |
| apply_pulse | output | 1 | One-cycle strobe on a 0-to-1 write of the global-reset bit |
| cfg_image | output | 952 | Parallel image of registers 0x00..0x76, register n at bits n*8+7:n*8 |

## Verification
The assertions check the following on every cycle:
- the fixed locations never change;
- the apply strobe lasts one cycle and coincides with the stored control bit having just risen;
- a stalled response keeps its data;
- the host stream stalls whenever a response waits.

Some behaviour can only be shown by the bench scenarios, which are compared against a behavioural model:
- which beats land in which registers;
- read values and their order;
- pointer saturation at the top of the map;
- the silence of out-of-range accesses;
- the absence of a pulse when the bit is rewritten as 1.

// File: rtl/cfgrf_pkg.sv
package cfgrf_pkg;

  typedef enum logic [1:0] {
    BEAT_NONE = 2'd0,
    BEAT_ADDR = 2'd1,
    BEAT_WR   = 2'd2,
    BEAT_RD   = 2'd3
  } beat_e;

  // A location is fixed when it sits in the bottom block or on one of the holes.
  function automatic bit addr_is_fixed(int unsigned a, int unsigned low_top,
                                       int unsigned h0, int unsigned h1,
                                       int unsigned h2);
    return (a <= low_top) || (a == h0) || (a == h1) || (a == h2);
  endfunction

endpackage

// File: rtl/cfgrf_host_port.sv
module cfgrf_host_port
  import cfgrf_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 8,
  parameter int unsigned LAST_ADDR = 'h76
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_valid,
  output logic          host_ready,
  input  logic          host_first,
  input  logic          host_write,
  input  logic [DW-1:0] host_data,
  output logic          resp_valid,
  input  logic          resp_ready,
  output logic [DW-1:0] resp_data,
  output beat_e         beat,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] acc_data,
  input  logic [DW-1:0] rd_value
);

  localparam logic [AW-1:0] LAST_A = AW'(LAST_ADDR);

  logic [AW-1:0] ptr_q;
  logic          take;

  assign host_ready = !resp_valid || resp_ready;
  assign take       = host_valid && host_ready;

  always_comb begin
    if (!take)          beat = BEAT_NONE;
    else if (host_first) beat = BEAT_ADDR;
    else if (host_write) beat = BEAT_WR;
    else                 beat = BEAT_RD;
  end

  // The pointer saturates at the last implemented address.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (beat == BEAT_ADDR) begin
      ptr_q <= AW'(host_data);
    end else if (beat == BEAT_WR || beat == BEAT_RD) begin
      if (ptr_q < LAST_A) ptr_q <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_data  <= '0;
    end else if (beat == BEAT_RD) begin
      resp_valid <= 1'b1;
      resp_data  <= rd_value;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end

  assign acc_addr = ptr_q;
  assign acc_data = host_data;

endmodule

// File: rtl/cfgrf_store.sv
module cfgrf_store
  import cfgrf_pkg::*;
#(
  parameter int unsigned AW         = 8,
  parameter int unsigned DW         = 8,
  parameter int unsigned LAST_ADDR  = 'h76,
  parameter int unsigned LOW_TOP    = 'h0F,
  parameter int unsigned HOLE_A     = 'h14,
  parameter int unsigned HOLE_B     = 'h1C,
  parameter int unsigned HOLE_C     = 'h1D,
  parameter int unsigned FIXED_MASK = 'h5A,
  localparam int unsigned NREG      = LAST_ADDR + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [AW-1:0]      rd_addr,
  output logic [DW-1:0]      rd_value,
  output logic [NREG*DW-1:0] image
);

  logic [DW-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [AW-1:0] MY_A = AW'(i);
    localparam bit FIXED = addr_is_fixed(i, LOW_TOP, HOLE_A, HOLE_B, HOLE_C);
    if (FIXED) begin : g_fixed
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs[i] <= DW'(i ^ FIXED_MASK);
        else        regs[i] <= regs[i];
      end
    end else begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           regs[i] <= '0;
        else if (wr_en && (wr_addr == MY_A)) regs[i] <= wr_data;
      end
    end
    assign image[i*DW +: DW] = regs[i];
  end

  // An address outside the map matches no entry and reads as zero.
  always_comb begin
    rd_value = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_addr == AW'(i)) rd_value = regs[i];
    end
  end

endmodule

// File: rtl/cfgrf_apply_det.sv
module cfgrf_apply_det #(
  parameter int unsigned AW         = 8,
  parameter int unsigned APPLY_ADDR = 'h76
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  input  logic          cur_bit,
  output logic          apply_pulse
);

  localparam logic [AW-1:0] APPLY_A = AW'(APPLY_ADDR);

  logic rise;

  // Only a write that lifts a stored 0 to 1 counts.
  assign rise = wr_en && (wr_addr == APPLY_A) && wr_bit && !cur_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) apply_pulse <= 1'b0;
    else        apply_pulse <= rise;
  end

endmodule

// File: rtl/cfgrf_top.sv
module cfgrf_top
  import cfgrf_pkg::*;
#(
  parameter int unsigned AW         = 8,
  parameter int unsigned DW         = 8,
  parameter int unsigned LAST_ADDR  = 'h76,
  parameter int unsigned LOW_TOP    = 'h0F,
  parameter int unsigned HOLE_A     = 'h14,
  parameter int unsigned HOLE_B     = 'h1C,
  parameter int unsigned HOLE_C     = 'h1D,
  parameter int unsigned FIXED_MASK = 'h5A,
  parameter int unsigned APPLY_ADDR = 'h76,
  parameter int unsigned APPLY_BIT  = 5,
  localparam int unsigned NREG      = LAST_ADDR + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_valid,
  output logic               host_ready,
  input  logic               host_first,
  input  logic               host_write,
  input  logic [DW-1:0]      host_data,
  output logic               resp_valid,
  input  logic               resp_ready,
  output logic [DW-1:0]      resp_data,
  output logic               apply_pulse,
  output logic [NREG*DW-1:0] cfg_image
);

  beat_e         beat;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] acc_data;
  logic [DW-1:0] rd_value;
  logic          wr_en;

  assign wr_en = (beat == BEAT_WR);

  cfgrf_host_port #(.AW(AW), .DW(DW), .LAST_ADDR(LAST_ADDR)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_valid (host_valid),
    .host_ready (host_ready),
    .host_first (host_first),
    .host_write (host_write),
    .host_data  (host_data),
    .resp_valid (resp_valid),
    .resp_ready (resp_ready),
    .resp_data  (resp_data),
    .beat       (beat),
    .acc_addr   (acc_addr),
    .acc_data   (acc_data),
    .rd_value   (rd_value)
  );

  cfgrf_store #(
    .AW(AW), .DW(DW), .LAST_ADDR(LAST_ADDR), .LOW_TOP(LOW_TOP),
    .HOLE_A(HOLE_A), .HOLE_B(HOLE_B), .HOLE_C(HOLE_C), .FIXED_MASK(FIXED_MASK)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (acc_addr),
    .wr_data  (acc_data),
    .rd_addr  (acc_addr),
    .rd_value (rd_value),
    .image    (cfg_image)
  );

  cfgrf_apply_det #(.AW(AW), .APPLY_ADDR(APPLY_ADDR)) u_apply (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (acc_addr),
    .wr_bit      (acc_data[APPLY_BIT]),
    .cur_bit     (cfg_image[APPLY_ADDR*DW + APPLY_BIT]),
    .apply_pulse (apply_pulse)
  );

endmodule

// File: rtl/cfgrf_checker.sv
module cfgrf_checker #(
  parameter int unsigned DW      = 8,
  parameter int unsigned LOW_TOP = 'h0F
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     apply_pulse,
  input logic                     ctl_bit,
  input logic [(LOW_TOP+1)*DW-1:0] low_bytes,
  input logic [3*DW-1:0]          hole_bytes,
  input logic                     resp_valid,
  input logic                     resp_ready,
  input logic [DW-1:0]            resp_data,
  input logic                     host_ready
);

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    apply_pulse |=> !apply_pulse);

  assert_pulse_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    apply_pulse |-> (ctl_bit && !$past(ctl_bit)));

  assert_low_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(low_bytes));

  assert_holes_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(hole_bytes));

  assert_resp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data)));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |-> !host_ready);

endmodule

bind cfgrf_top cfgrf_checker #(.DW(DW), .LOW_TOP(LOW_TOP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .apply_pulse (apply_pulse),
  .ctl_bit     (cfg_image[APPLY_ADDR*DW + APPLY_BIT]),
  .low_bytes   (cfg_image[(LOW_TOP+1)*DW-1:0]),
  .hole_bytes  ({cfg_image[HOLE_A*DW +: DW], cfg_image[HOLE_B*DW +: DW],
                 cfg_image[HOLE_C*DW +: DW]}),
  .resp_valid  (resp_valid),
  .resp_ready  (resp_ready),
  .resp_data   (resp_data),
  .host_ready  (host_ready)
);

// File: tb/cfgrf_top_tb.sv
module cfgrf_top_tb;

  localparam int NREG = 119;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_valid = 1'b0;
  logic host_first = 1'b0;
  logic host_write = 1'b0;
  logic [7:0] host_data = 8'h00;
  logic resp_ready = 1'b1;
  logic host_ready, resp_valid, apply_pulse;
  logic [7:0] resp_data;
  logic [NREG*8-1:0] cfg_image;

  always #10 clk = ~clk;

  cfgrf_top u_dut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_first(host_first), .host_write(host_write), .host_data(host_data),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(resp_data),
    .apply_pulse(apply_pulse), .cfg_image(cfg_image)
  );

  int tests = 0;
  int fails = 0;
  int pulses = 0;
  bit done = 0;
  logic [7:0] rq[$];

  // Behavioural reference state.
  int m_mem [0:255];
  int m_ptr;
  bit m_rv;
  int m_rd;
  bit m_ap;

  function automatic bit fixed_loc(int a);
    return (a < 16) || a == 'h14 || a == 'h1C || a == 'h1D;
  endfunction

  function automatic logic [7:0] img(int a);
    return cfg_image[a*8 +: 8];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < 256; a++) m_mem[a] = (a <= 'h76 && fixed_loc(a)) ? (a ^ 'h5A) : 0;
      m_ptr = 0; m_rv = 0; m_rd = 0; m_ap = 0;
    end else begin
      bit acc;
      acc = host_valid && (!m_rv || resp_ready);
      if (m_rv && resp_ready) m_rv = 0;
      m_ap = 0;
      if (acc && host_first) begin
        m_ptr = host_data;
      end else if (acc) begin
        if (host_write) begin
          if (m_ptr == 'h76 && host_data[5] && !m_mem['h76][5]) m_ap = 1;
          if (m_ptr <= 'h76 && !fixed_loc(m_ptr)) m_mem[m_ptr] = host_data;
        end else begin
          m_rv = 1;
          m_rd = (m_ptr <= 'h76) ? m_mem[m_ptr] : 0;
        end
        if (m_ptr < 'h76) m_ptr++;
      end
    end
  end

  // Compare with the model just before each rising edge.
  always @(negedge clk) begin
    #8;
    if (rst_n && !done) begin
      bit img_ok;
      int bad;
      img_ok = 1; bad = 0;
      for (int a = 0; a < NREG; a++)
        if (img_ok && img(a) != m_mem[a][7:0]) begin img_ok = 0; bad = a; end
      chk(img_ok, "R2 R4 R5 R6 image", img(bad), m_mem[bad]);
      chk(resp_valid == m_rv, "R3 resp_valid", resp_valid, m_rv);
      if (m_rv) chk(resp_data == m_rd[7:0], "R3 R6 resp_data", resp_data, m_rd);
      chk(apply_pulse == m_ap, "R8 R9 apply_pulse", apply_pulse, m_ap);
      chk(host_ready == (!m_rv || resp_ready), "R10 host_ready", host_ready, !m_rv || resp_ready);
      if (resp_valid && resp_ready) rq.push_back(resp_data);
      if (apply_pulse) pulses++;
    end
  end

  task automatic beat(input bit f, input bit w, input logic [7:0] d);
    @(negedge clk);
    #1;
    host_valid = 1; host_first = f; host_write = w; host_data = d;
    while (!host_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    #1;
    host_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int p0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    #2;
    // R1 reset state
    chk(img(3) == 8'h59, "R1 fixed reset", img(3), 8'h59);
    chk(img('h14) == 8'h4E, "R1 hole reset", img('h14), 8'h4E);
    chk(img('h20) == 8'h00, "R1 rw reset", img('h20), 0);
    chk(!resp_valid && !apply_pulse, "R1 outputs", resp_valid, 0);

    // R2 burst write at 0x17
    beat(1, 0, 8'h17);
    beat(0, 1, 8'h11); beat(0, 1, 8'h22); beat(0, 1, 8'h33);
    beat(0, 1, 8'h44); beat(0, 1, 8'h55);
    idle(1);
    chk(img('h17) == 8'h11 && img('h1B) == 8'h55, "R2 burst", img('h1B), 8'h55);
    chk(img('h19) == 8'h33, "R2 middle", img('h19), 8'h33);

    // R11 address beat alone
    beat(1, 0, 8'h40);
    idle(2);
    chk(!resp_valid && img('h40) == 0, "R11 addr only", resp_valid, 0);

    // R4 bottom block ignores writes
    beat(1, 0, 8'h05); beat(0, 1, 8'hFF);
    idle(1);
    chk(img(5) == 8'h5F, "R4 write ignored", img(5), 8'h5F);

    // R5 hole inside a burst
    beat(1, 0, 8'h13);
    beat(0, 1, 8'hA1); beat(0, 1, 8'hA2); beat(0, 1, 8'hA3);
    idle(1);
    chk(img('h13) == 8'hA1, "R5 before hole", img('h13), 8'hA1);
    chk(img('h14) == 8'h4E, "R5 hole kept", img('h14), 8'h4E);
    chk(img('h15) == 8'hA3, "R5 after hole", img('h15), 8'hA3);

    // R3 read burst and a fixed read
    rq.delete();
    beat(1, 0, 8'h17);
    beat(0, 0, 0); beat(0, 0, 0); beat(0, 0, 0);
    beat(1, 0, 8'h0A); beat(0, 0, 0);
    idle(3);
    chk(rq.size() == 4, "R3 count", rq.size(), 4);
    if (rq.size() == 4) begin
      chk(rq[0] == 8'h11 && rq[1] == 8'h22 && rq[2] == 8'h33, "R3 order", rq[2], 8'h33);
      chk(rq[3] == 8'h50, "R4 fixed read", rq[3], 8'h50);
    end

    // R6 out of range
    rq.delete();
    beat(1, 0, 8'h80); beat(0, 1, 8'h77); beat(0, 0, 0);
    idle(3);
    chk(rq.size() == 1 && rq[0] == 8'h00, "R6 read zero", rq.size() ? rq[0] : 8'hEE, 0);

    // R7 saturation at 0x76
    beat(1, 0, 8'h75);
    beat(0, 1, 8'hC1); beat(0, 1, 8'hE2); beat(0, 1, 8'hE3);
    idle(1);
    chk(img('h75) == 8'hC1, "R7 first", img('h75), 8'hC1);
    chk(img('h76) == 8'hE3, "R7 overwrite top", img('h76), 8'hE3);
    rq.delete();
    beat(1, 0, 8'h75); beat(0, 0, 0); beat(0, 0, 0); beat(0, 0, 0);
    idle(3);
    chk(rq.size() == 3 && rq[1] == 8'hE3 && rq[2] == 8'hE3, "R7 read sat",
        rq.size() == 3 ? rq[2] : 8'hEE, 8'hE3);

    // R8 0 then 1, R9 1 again
    p0 = pulses;
    beat(1, 0, 8'h76); beat(0, 1, 8'h00); beat(0, 1, 8'h20);
    idle(2);
    chk(pulses == p0 + 1, "R8 one pulse", pulses - p0, 1);
    beat(0, 1, 8'h20);
    idle(2);
    chk(pulses == p0 + 1, "R9 no pulse", pulses - p0, 1);

    // R10 back-pressure
    rq.delete();
    resp_ready = 0;
    beat(1, 0, 8'h17); beat(0, 0, 0);
    @(negedge clk); #1;
    host_valid = 1; host_first = 0; host_write = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #2;
      chk(!host_ready && resp_valid && resp_data == 8'h11, "R10 stall", resp_data, 8'h11);
    end
    resp_ready = 1;
    @(posedge clk);
    idle(3);
    chk(rq.size() == 2 && rq[0] == 8'h11 && rq[1] == 8'h22, "R10 drain",
        rq.size() == 2 ? rq[1] : 8'hEE, 8'h22);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule